// File: doc/BRIEF.md
# SPI Mode-3 Register Slave

This block lets a host processor reach a byte-addressed register map over a four-wire serial bus. The bus idles with its clock high. The host changes data on the falling clock edge and captures it on the rising edge. Every transaction is a sixteen-bit word, sent most significant bit first in both directions. The bus pins are first brought into the system clock domain through a synchronizer chain. Clock edges are then found by comparing successive synchronized samples. For this to work, the system clock must run at least eight times faster than the serial clock.

Each incoming word is either a read command or a single-byte write. A read command names a byte address. The whole sixteen-bit register behind that address comes back on the data-out pin during the next word. Because the link is full duplex, the host can send its next address in the same word that carries the previous result back. A write changes one byte and takes effect only when its word has completed. A pulse marks each completed word and presents the received bits, so a neighbouring sequencer can watch the traffic at frame level.

Top module: `spi_mode3_regslave`

## Requirements
- R1: After reset, `miso`, `miso_oe`, `rf_wr_en` and `frame_done` are all low.
- R2: A word whose bit 15 is 0 is a read command, and bits 14:8 hold its 7-bit byte address. The addressed 16-bit register shifts out on `miso` during the next word, MSB first. Each bit is driven after a falling `sclk` edge and is valid at the following rising edge.
- R3: Byte address 2k is the lower byte of word k and 2k+1 is its upper byte. A read at either address returns the full word k and sets `rf_rd_word` to k. Bits 7:0 of a read command have no effect.
- R4: A word whose bit 15 is 1 is a write, and it raises `rf_wr_en` for exactly one cycle at the end of the word. The byte address is bits 13:8, and bit 14 is ignored. `rf_wr_word` carries bits 13:9, `rf_wr_upper` carries bit 8 (1 means the upper byte), and `rf_wr_byte` carries bits 7:0.
- R5: The word that follows a write returns all zeros on `miso`.
- R6: The first word after `cs_n` falls returns all zeros on `miso`.
- R7: If `cs_n` rises before the sixteenth rising edge, the word is dropped. No write takes place, no `frame_done` pulse appears and `rf_rd_word` stays unchanged. `sclk` activity while `cs_n` is high is ignored.
- R8: `miso_oe` is high exactly while `cs_n` is low, after synchronization. While `miso_oe` is low, `miso` is 0.
- R9: Every complete word produces a single-cycle `frame_done` pulse, and `frame_word` then equals the 16 bits received.
- R10: Reads can be chained without gaps: in each word, the data returned answers the command sent in the word before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host, idles high |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the data-out pin |
| rf_rd_word | output | 6 | Word index of the register being read |
| rf_rd_data | input | 16 | Register-file read data for `rf_rd_word` |
| rf_wr_en | output | 1 | One-cycle byte write strobe |
| rf_wr_word | output | 5 | Word index of the byte write |
| rf_wr_upper | output | 1 | 1 selects the upper byte of the word |
| rf_wr_byte | output | 8 | Byte written |
| frame_done | output | 1 | One-cycle pulse per complete word |
| frame_word | output | 16 | Last complete word received |

## Verification
The bench builds the block with its default two-stage synchronizer and seven-bit read address, and runs the serial clock at one sixteenth of the system clock. It issues read commands to all 128 byte addresses in one chained burst. It then writes both bytes of every writable word, setting bit 14 on half of them, and reads back all 64 word locations. These sweeps reach every address decode path and both byte lanes. Aborted writes and aborted reads, idle clocking with chip select high, and the zero-return rules are driven as separate scenarios.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;

    localparam int FRAME_W   = 16;
    localparam int ADDR_W    = 7;
    localparam int BYTE_W    = 8;
    localparam int RD_WORD_W = ADDR_W - 1;
    localparam int WR_WORD_W = ADDR_W - 2;
    localparam int CNT_W     = $clog2(FRAME_W);

    // Frame layout: {write flag, byte address, data byte}
    typedef struct packed {
        logic              is_write;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        LOAD_NONE = 2'd0,
        LOAD_ZERO = 2'd1,
        LOAD_REG  = 2'd2
    } load_e;

    function automatic frame_t to_frame(input logic [FRAME_W-1:0] w);
        return frame_t'(w);
    endfunction

    function automatic logic [RD_WORD_W-1:0] rd_word_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:1];
    endfunction

endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge
    import spi_regslave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic mosi_s
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] IDLE = 3'b110; // {sclk, cs_n, mosi}

    logic [NSIG-1:0] raw;
    logic [SYNC_STAGES-1:0][NSIG-1:0] pipe;
    logic [NSIG-1:0] synced;
    logic sclk_d;

    assign raw    = {sclk_i, cs_n_i, mosi_i};
    assign synced = pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= IDLE;
            sclk_d <= 1'b1;
        end else begin
            pipe[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
            sclk_d <= synced[2];
        end
    end

    assign sclk_rise = synced[2] & ~sclk_d;
    assign sclk_fall = ~synced[2] & sclk_d;
    assign cs_active = ~synced[1];
    assign mosi_s    = synced[0];

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import spi_regslave_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    input  logic               cs_active,
    input  logic               mosi_s,
    input  logic               tx_load,
    input  logic [FRAME_W-1:0] tx_word,
    output logic               frame_done,
    output logic [FRAME_W-1:0] frame_word,
    output logic               miso_bit
);
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] rx_sr;
    logic [FRAME_W-1:0] tx_sr;
    logic [FRAME_W-1:0] rx_next;

    assign rx_next = {rx_sr[FRAME_W-2:0], mosi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_word <= '0;
        end else if (cs_active && sclk_rise && bit_cnt == CNT_W'(FRAME_W - 1)) begin
            frame_word <= rx_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !cs_active) begin
            bit_cnt    <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            miso_bit   <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (sclk_rise) begin
                rx_sr   <= rx_next;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(FRAME_W - 1)) frame_done <= 1'b1;
            end
            if (sclk_fall) begin
                miso_bit <= tx_sr[FRAME_W-1];
                tx_sr    <= {tx_sr[FRAME_W-2:0], 1'b0};
            end
            if (tx_load) tx_sr <= tx_word;
        end
    end

endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_regslave_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_active,
    input  logic                 frame_done,
    input  logic [FRAME_W-1:0]   frame_word,
    output logic [RD_WORD_W-1:0] rf_rd_word,
    output logic                 rf_wr_en,
    output logic [WR_WORD_W-1:0] rf_wr_word,
    output logic                 rf_wr_upper,
    output logic [BYTE_W-1:0]    rf_wr_byte,
    output load_e                load_kind
);
    frame_t f;
    assign f = to_frame(frame_word);

    // Write address drops the top address bit of the frame.
    assign rf_wr_en    = frame_done & f.is_write;
    assign rf_wr_word  = f.addr[ADDR_W-2:1];
    assign rf_wr_upper = f.addr[0];
    assign rf_wr_byte  = f.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_rd_word <= '0;
            load_kind  <= LOAD_NONE;
        end else if (!cs_active) begin
            load_kind  <= LOAD_NONE;
        end else begin
            load_kind <= LOAD_NONE;
            if (frame_done) begin
                if (f.is_write) begin
                    load_kind <= LOAD_ZERO;
                end else begin
                    rf_rd_word <= rd_word_of(f.addr);
                    load_kind  <= LOAD_REG;
                end
            end
        end
    end

endmodule

// File: rtl/spi_mode3_regslave.sv
module spi_mode3_regslave
    import spi_regslave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sclk,
    input  logic                 cs_n,
    input  logic                 mosi,
    output logic                 miso,
    output logic                 miso_oe,
    output logic [RD_WORD_W-1:0] rf_rd_word,
    input  logic [FRAME_W-1:0]   rf_rd_data,
    output logic                 rf_wr_en,
    output logic [WR_WORD_W-1:0] rf_wr_word,
    output logic                 rf_wr_upper,
    output logic [BYTE_W-1:0]    rf_wr_byte,
    output logic                 frame_done,
    output logic [FRAME_W-1:0]   frame_word
);
    logic sclk_rise, sclk_fall, cs_active, mosi_s, miso_bit;
    logic tx_load;
    logic [FRAME_W-1:0] tx_word;
    load_e load_kind;

    spi_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_active(cs_active), .mosi_s(mosi_s)
    );

    spi_frame_shifter u_shift (
        .clk(clk), .rst(rst),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_active(cs_active), .mosi_s(mosi_s),
        .tx_load(tx_load), .tx_word(tx_word),
        .frame_done(frame_done), .frame_word(frame_word),
        .miso_bit(miso_bit)
    );

    spi_cmd_decode u_dec (
        .clk(clk), .rst(rst),
        .cs_active(cs_active),
        .frame_done(frame_done), .frame_word(frame_word),
        .rf_rd_word(rf_rd_word),
        .rf_wr_en(rf_wr_en), .rf_wr_word(rf_wr_word),
        .rf_wr_upper(rf_wr_upper), .rf_wr_byte(rf_wr_byte),
        .load_kind(load_kind)
    );

    assign tx_load = (load_kind != LOAD_NONE);
    assign tx_word = (load_kind == LOAD_REG) ? rf_rd_data : '0;

    assign miso_oe = cs_active;
    assign miso    = cs_active & miso_bit;

endmodule

// File: rtl/spi_mode3_regslave_chk.sv
module spi_mode3_regslave_chk (
    input logic        clk,
    input logic        rst,
    input logic        miso,
    input logic        miso_oe,
    input logic        rf_wr_en,
    input logic        frame_done,
    input logic [15:0] frame_word
);
    // R8
    miso_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !miso_oe |-> !miso);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R4
    wr_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> (frame_done && frame_word[15]));

    // R4
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |=> !rf_wr_en);

    // R7
    done_under_cs_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> miso_oe);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!miso && !rf_wr_en && !frame_done));

endmodule

bind spi_mode3_regslave spi_mode3_regslave_chk u_chk (
    .clk(clk), .rst(rst), .miso(miso), .miso_oe(miso_oe),
    .rf_wr_en(rf_wr_en), .frame_done(frame_done), .frame_word(frame_word)
);

// File: tb/spi_mode3_regslave_bench.sv
`timescale 1ns/1ps
module spi_mode3_regslave_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe, rf_wr_en, rf_wr_upper, frame_done;
    logic [5:0]  rf_rd_word;
    logic [15:0] rf_rd_data, frame_word;
    logic [4:0]  rf_wr_word;
    logic [7:0]  rf_wr_byte;

    localparam int HALF = 40;

    int checks = 0, errors = 0;
    int wr_cnt = 0, done_cnt = 0;
    logic [4:0] cap_word;
    logic       cap_upper;
    logic [7:0] cap_byte;
    logic [15:0] rf_mem [64];
    logic [15:0] expv [64];

    always #2.5 clk = ~clk;

    spi_mode3_regslave u_spi_mode3_regslave (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe),
        .rf_rd_word(rf_rd_word), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_word(rf_wr_word),
        .rf_wr_upper(rf_wr_upper), .rf_wr_byte(rf_wr_byte),
        .frame_done(frame_done), .frame_word(frame_word)
    );

    assign rf_rd_data = rf_mem[rf_rd_word];

    function automatic logic [15:0] init_val(input int i);
        return 16'((i * 16'h0103) ^ 16'h5A3C);
    endfunction

    initial for (int i = 0; i < 64; i++) rf_mem[i] = init_val(i);

    always @(posedge clk) begin
        if (rf_wr_en) begin
            wr_cnt    <= wr_cnt + 1;
            cap_word  <= rf_wr_word;
            cap_upper <= rf_wr_upper;
            cap_byte  <= rf_wr_byte;
            if (rf_wr_upper) rf_mem[{1'b0, rf_wr_word}][15:8] <= rf_wr_byte;
            else             rf_mem[{1'b0, rf_wr_word}][7:0]  <= rf_wr_byte;
        end
        if (frame_done) done_cnt <= done_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [15:0] din, input int nbits, output logic [15:0] dout);
        dout = '0;
        for (int i = 15; i > 15 - nbits; i--) begin
            mosi = din[i];
            sclk = 1'b0;
            #HALF;
            dout[i] = miso;
            sclk = 1'b1;
            #HALF;
        end
    endtask

    task automatic select(input logic lvl);
        cs_n = lvl;
        #(2 * HALF);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int base_done, base_wr;
        for (int i = 0; i < 64; i++) expv[i] = init_val(i);
        repeat (10) @(posedge clk);
        #1 rst = 1'b0;
        #20;
        // R1 reset state
        check(miso == 0 && miso_oe == 0 && rf_wr_en == 0 && frame_done == 0, "R1",
              {miso, miso_oe, rf_wr_en, frame_done}, 0);

        // R2 R3 R6 R10: chained read over all byte addresses
        base_done = done_cnt;
        select(1'b0);
        check(miso_oe == 1, "R8 oe on", miso_oe, 1);
        for (int k = 0; k <= 128; k++) begin
            logic [15:0] cmd;
            cmd = {1'b0, 7'(k < 128 ? k : 0), 8'(k * 37)};
            xfer(cmd, 16, d);
            if (k == 0) check(d == 0, "R6 first frame zero", d, 0);
            else        check(d == expv[(k-1) >> 1], "R2 R3 R10 read data", d, expv[(k-1) >> 1]);
            if (k == 5) check(frame_word == cmd, "R9 frame_word", frame_word, cmd);
            if (k == 9) check(rf_rd_word == 6'(k >> 1), "R3 rd word index", rf_rd_word, k >> 1);
        end
        check(done_cnt - base_done == 129, "R9 frame count", done_cnt - base_done, 129);
        select(1'b1);

        // R8 R7: idle with cs high, sclk toggling
        base_done = done_cnt;
        for (int i = 0; i < 20; i++) begin
            mosi = i[0]; sclk = 1'b0; #HALF; sclk = 1'b1; #HALF;
            if (i == 10) check(miso == 0 && miso_oe == 0, "R8 idle outputs", {miso, miso_oe}, 0);
        end
        check(done_cnt == base_done, "R7 sclk ignored while deselected", done_cnt - base_done, 0);

        // R4 R5: write both bytes of every writable word
        select(1'b0);
        for (int w = 0; w < 32; w++) begin
            for (int hb = 0; hb < 2; hb++) begin
                logic [7:0]  dat;
                logic [15:0] cmd;
                dat = 8'(w * 29 + hb * 101 + 7);
                cmd = {1'b1, 1'(w), 5'(w), 1'(hb), dat};
                base_wr = wr_cnt;
                xfer(cmd, 16, d);
                if (w == 0 && hb == 0) check(d == 0, "R6 first frame zero", d, 0);
                else                   check(d == 0, "R5 zero after write", d, 0);
                check(wr_cnt == base_wr + 1 && cap_word == 5'(w) && cap_upper == 1'(hb) && cap_byte == dat,
                      "R4 write strobe fields", {wr_cnt - base_wr, cap_word, cap_upper, cap_byte},
                      {32'd1, 5'(w), 1'(hb), dat});
                if (hb == 1) expv[w][15:8] = dat; else expv[w][7:0] = dat;
            end
        end
        // readback through odd addresses
        for (int k = 0; k <= 64; k++) begin
            xfer({1'b0, 7'(k < 64 ? 2 * k + 1 : 0), 8'hFF}, 16, d);
            if (k == 0) check(d == 0, "R5 zero after write", d, 0);
            else        check(d == expv[k-1], "R4 R3 readback", d, expv[k-1]);
        end
        select(1'b1);

        // R7: aborted write
        base_wr = wr_cnt;
        base_done = done_cnt;
        select(1'b0);
        xfer({1'b1, 7'd7, 8'hEE}, 12, d);
        select(1'b1);
        check(wr_cnt == base_wr, "R7 no write on abort", wr_cnt - base_wr, 0);
        check(done_cnt == base_done, "R7 no frame_done on abort", done_cnt - base_done, 0);

        // R7: aborted read keeps read index
        select(1'b0);
        xfer({1'b0, 7'h12, 8'h00}, 16, d);
        xfer({1'b0, 7'h20, 8'h00}, 12, d);
        select(1'b1);
        check(rf_rd_word == 6'd9, "R7 read index kept", rf_rd_word, 9);

        select(1'b0);
        xfer({1'b0, 7'd7, 8'h00}, 16, d);
        check(d == 0, "R6 first frame zero", d, 0);
        xfer(16'h0000, 16, d);
        check(d == expv[3], "R7 word unchanged", d, expv[3]);
        select(1'b1);
        check(miso == 0 && miso_oe == 0, "R8 deselected outputs", {miso, miso_oe}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule